// File: doc/BRIEF.md
# Serial EEPROM Slave Controller (SPI, 256 x 8)

This block is the slave side of a small serial EEPROM on an SPI bus. The bus pins (serial clock, active-low select, serial data in, active-low pause, active-low write protect) are sampled through two-flop synchronisers and their edges are found in the system clock domain. Eight-bit commands arrive MSB first. The block serves sequential array reads, page writes of up to four bytes, and reads and writes of an 8-bit status byte. The serial output comes with a separate drive-enable, so the pad can be tri-stated.

Write data is collected in a four-byte page buffer. It reaches the register-based storage only when select rises exactly on a byte boundary and a protection unit accepts the request. An accepted write starts a write cycle. The cycle is modelled as a handshake: a one-cycle start pulse goes out, and the block stays busy until the system reports completion. A pause input freezes a transfer at the bit where it stopped. Three levels of upper-array protection are chosen through the status byte.

Top module: `spi_eeprom_slave`

## Requirements
- R1: SPI modes 0 and 3 are both served. SI is taken on rising SCK edges and SO changes only after falling SCK edges. Every command, address and data byte is sent MSB first.
- R2: Command 0x03 followed by an address streams bytes starting at that address. The address steps up after each byte and wraps from 0xFF to 0x00.
- R3: Command 0x02 followed by an address and data bytes stores the bytes at consecutive addresses. Only the low two address bits advance, so a fifth byte overwrites the first byte position of the same page.
- R4: An array or status write is committed only if select rises after at least one whole data byte and at a byte boundary. Any other rise discards the write and leaves the enable latch unchanged.
- R5: Command 0x06 sets the write-enable latch and 0x04 clears it. A commit needs the latch set and the protect pin high. A committed write clears the latch.
- R6: Command 0x05 shifts out the status byte: bit 0 busy, bit 1 enable latch, bits 3:2 protect level, bits 7:4 zero. While busy, every bit reads as 1.
- R7: Command 0x01 plus one byte loads the protect level from data bits 3:2. Level 1 guards 0xC0–0xFF, level 2 guards 0x80–0xFF and level 3 guards the whole array. A write to a guarded page is discarded.
- R8: so_oe_o stays low while select is high, for unknown commands, and until select has fallen once after reset.
- R9: Pulling the pause pin low while SCK is low freezes the transfer and drops so_oe_o. SCK and SI changes are ignored while paused. Releasing the pin while SCK is low resumes at the same bit.
- R10: A commit raises wcyc_start_o for one cycle. The block then stays busy until wcyc_done_i, and while busy it ignores every command except 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the bus master |
| cs_n_i | input | 1 | Active-low device select |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Active-low transfer pause |
| wp_n_i | input | 1 | Active-low write protect |
| wcyc_done_i | input | 1 | Write cycle completion pulse |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Drive enable for so_o |
| wcyc_start_o | output | 1 | One-cycle pulse when a write is committed |

## Verification
The assertions assume that SCK, select and pause change no faster than once every few system clocks, because edges are found after synchronisation. They also assume that pause and select are moved only while SCK is low, so a serial edge and a select or pause edge never land in the same system cycle. The bench drives each SCK half period for six system clocks. It changes select and pause only with SCK low and at least one half period away from any SCK edge. It pulses wcyc_done_i only after a write cycle has been started.

// File: rtl/spi_ee_pkg.sv
// Shared command codes and frame phases for the serial EEPROM slave.
// Assumes 8-bit commands sent MSB first.
package spi_ee_pkg;
    localparam logic [7:0] CMD_WEN_SET = 8'h06;
    localparam logic [7:0] CMD_WEN_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD = 8'h05;
    localparam logic [7:0] CMD_STAT_WR = 8'h01;
    localparam logic [7:0] CMD_ARR_RD  = 8'h03;
    localparam logic [7:0] CMD_ARR_WR  = 8'h02;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADR_RD, PH_ADR_WR, PH_DAT_RD,
        PH_DAT_WR, PH_STAT_RD, PH_STAT_WR, PH_SKIP
    } phase_e;
endpackage

// File: rtl/spi_ee_sync.sv
// Brings N asynchronous pins into the clock domain through STAGES flops each.
// Assumes every pin is slow compared with clk. RST_VAL gives each pin's reset level.
module spi_ee_sync #(
    parameter int N = 5,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        // shift the pin through its synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], async_i[g]};
        end
        assign level_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_ee_protocol.sv
// Frame engine: finds serial edges, shifts command, address and data bits,
// stages page-write bytes and drives the serial output.
// Assumes synchronised inputs and SCK at least 4x slower than clk.
module spi_ee_protocol #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int PAGE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck_lvl,
    input  logic                 cs_n_lvl,
    input  logic                 si_lvl,
    input  logic                 hold_n_lvl,
    input  logic                 busy,
    input  logic [DW-1:0]        status,
    input  logic [DW-1:0]        rd_data,
    output logic [AW-1:0]        rd_addr,
    output logic                 wel_set,
    output logic                 wel_clr,
    output logic                 arr_commit,
    output logic                 sr_commit,
    output logic [AW-PW-1:0]     page_base,
    output logic [1:0]           region,
    output logic [PAGE*DW-1:0]   stage_data,
    output logic [PAGE-1:0]      stage_mask,
    output logic [1:0]           sr_level,
    output logic                 so_o,
    output logic                 so_oe_o
);
    import spi_ee_pkg::*;
    localparam int PW = $clog2(PAGE);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    logic          sck_q, cs_q, hold_q;
    logic          sck_rise, sck_fall, cs_fall, cs_rise, hold_fall, hold_rise;
    logic          sel, paused, got_data, so_q;
    phase_e        phase;
    logic [BW-1:0] bit_cnt, out_cnt;
    logic [DW-1:0] rx_sh, tx_sh, rx_byte, tx_src;
    logic [AW-1:0] addr;
    logic [DW-1:0] stage [PAGE];
    logic          byte_done, rd_phase;

    // remember last synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_q   <= 1'b0;
            hold_q <= 1'b1;
        end else begin
            sck_q  <= sck_lvl;
            cs_q   <= cs_n_lvl;
            hold_q <= hold_n_lvl;
        end
    end

    assign sck_rise  = sck_lvl & ~sck_q;
    assign sck_fall  = ~sck_lvl & sck_q;
    assign cs_fall   = ~cs_n_lvl & cs_q;
    assign cs_rise   = cs_n_lvl & ~cs_q;
    assign hold_fall = ~hold_n_lvl & hold_q;
    assign hold_rise = hold_n_lvl & ~hold_q;

    assign rx_byte   = {rx_sh[DW-2:0], si_lvl};
    assign byte_done = sel & ~paused & sck_rise & (bit_cnt == LAST_BIT);
    assign rd_phase  = (phase == PH_DAT_RD) || (phase == PH_STAT_RD);
    assign tx_src    = (phase == PH_STAT_RD) ? status : rd_data;

    // latch-control pulses when a whole command byte lands
    assign wel_set = byte_done && phase == PH_CMD && !busy && rx_byte == CMD_WEN_SET;
    assign wel_clr = byte_done && phase == PH_CMD && !busy && rx_byte == CMD_WEN_CLR;

    // write requests only on a select rise at a byte boundary after data
    assign arr_commit = cs_rise && sel && phase == PH_DAT_WR && got_data && bit_cnt == '0;
    assign sr_commit  = cs_rise && sel && phase == PH_STAT_WR && got_data && bit_cnt == '0;

    // frame state: selection, pause, bit shifting, staging and output shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel        <= 1'b0;
            paused     <= 1'b0;
            phase      <= PH_SKIP;
            bit_cnt    <= '0;
            out_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            addr       <= '0;
            got_data   <= 1'b0;
            stage_mask <= '0;
            sr_level   <= '0;
            so_q       <= 1'b0;
            for (int i = 0; i < PAGE; i++) stage[i] <= '0;
        end else if (cs_fall) begin
            sel        <= 1'b1;
            paused     <= 1'b0;
            phase      <= PH_CMD;
            bit_cnt    <= '0;
            out_cnt    <= '0;
            got_data   <= 1'b0;
            stage_mask <= '0;
            so_q       <= 1'b0;
        end else if (cs_n_lvl) begin
            sel    <= 1'b0;
            paused <= 1'b0;
        end else if (sel) begin
            if (paused) begin
                if (hold_rise && !sck_lvl) paused <= 1'b0;
            end else if (hold_fall && !sck_lvl) begin
                paused <= 1'b1;
            end else begin
                if (sck_rise) begin
                    bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                    rx_sh   <= rx_byte;
                    if (byte_done) begin
                        case (phase)
                            PH_CMD: begin
                                if (busy && rx_byte != CMD_STAT_RD) phase <= PH_SKIP;
                                else begin
                                    case (rx_byte)
                                        CMD_ARR_RD:  phase <= PH_ADR_RD;
                                        CMD_ARR_WR:  phase <= PH_ADR_WR;
                                        CMD_STAT_RD: phase <= PH_STAT_RD;
                                        CMD_STAT_WR: phase <= PH_STAT_WR;
                                        default:     phase <= PH_SKIP;
                                    endcase
                                end
                            end
                            PH_ADR_RD: begin
                                addr  <= rx_byte[AW-1:0];
                                phase <= PH_DAT_RD;
                            end
                            PH_ADR_WR: begin
                                addr  <= rx_byte[AW-1:0];
                                phase <= PH_DAT_WR;
                            end
                            PH_DAT_WR: begin
                                stage[addr[PW-1:0]]      <= rx_byte;
                                stage_mask[addr[PW-1:0]] <= 1'b1;
                                addr[PW-1:0]             <= addr[PW-1:0] + 1'b1;
                                got_data                 <= 1'b1;
                            end
                            PH_STAT_WR: begin
                                sr_level <= rx_byte[3:2];
                                got_data <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                if (sck_fall && rd_phase) begin
                    if (out_cnt == '0) begin
                        so_q  <= tx_src[DW-1];
                        tx_sh <= {tx_src[DW-2:0], 1'b0};
                    end else begin
                        so_q  <= tx_sh[DW-1];
                        tx_sh <= {tx_sh[DW-2:0], 1'b0};
                    end
                    out_cnt <= (out_cnt == LAST_BIT) ? '0 : out_cnt + 1'b1;
                    if (out_cnt == LAST_BIT && phase == PH_DAT_RD) addr <= addr + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < PAGE; g++) begin : g_flat
        assign stage_data[g*DW +: DW] = stage[g];
    end

    assign rd_addr   = addr;
    assign page_base = addr[AW-1:PW];
    assign region    = addr[AW-1 -: 2];
    assign so_o      = so_q;
    assign so_oe_o   = sel & ~paused & rd_phase;

    // R1: serial output moves only after a falling SCK or a new frame
    p_so_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so_q) |-> ($past(sck_fall) || $past(cs_fall)));
    // R9: a paused frame keeps its bit position and phase
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> ($stable(bit_cnt) && $stable(phase)));
    // R8: output is released once select has been high for a cycle
    p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n_lvl) && cs_n_lvl) |-> !so_oe_o);
endmodule

// File: rtl/spi_ee_guard.sv
// Protection and status unit: holds the write-enable latch, the protect level
// and the busy flag, and grants or refuses committed write requests.
// Assumes wcyc_done_i is synchronous to clk.
module spi_ee_guard #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_n_lvl,
    input  logic          wel_set,
    input  logic          wel_clr,
    input  logic          arr_commit,
    input  logic          sr_commit,
    input  logic [1:0]    region,
    input  logic [1:0]    sr_level,
    input  logic          wcyc_done_i,
    output logic          busy,
    output logic          arr_grant,
    output logic [DW-1:0] status,
    output logic          wcyc_start_o
);
    logic       wel, start_q, may_write, guarded, sr_grant;
    logic [1:0] level;

    // decide whether the addressed quarter of the array is guarded
    always_comb begin
        case (level)
            2'd1:    guarded = (region == 2'd3);
            2'd2:    guarded = region[1];
            2'd3:    guarded = 1'b1;
            default: guarded = 1'b0;
        endcase
    end

    assign may_write = wel & wp_n_lvl & ~busy;
    assign arr_grant = arr_commit & may_write & ~guarded;
    assign sr_grant  = sr_commit & may_write;

    // latch, protect level and busy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel     <= 1'b0;
            level   <= 2'd0;
            busy    <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= arr_grant | sr_grant;
            if (wel_set) wel <= 1'b1;
            if (wel_clr) wel <= 1'b0;
            if (sr_grant) level <= sr_level;
            if (arr_grant || sr_grant) begin
                wel  <= 1'b0;
                busy <= 1'b1;
            end else if (busy && wcyc_done_i) begin
                busy <= 1'b0;
            end
        end
    end

    assign status       = busy ? '1 : {{(DW-4){1'b0}}, level, wel, 1'b0};
    assign wcyc_start_o = start_q;

    // R5: a write cycle begins only from an enabled, unprotected state
    p_busy_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wel) && $past(wp_n_lvl)));
    // R5: the enable latch is consumed by the commit
    p_wel_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !wel);
    // R10: busy lasts until the completion pulse
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wcyc_done_i) |=> busy);
    // R10: every start pulse follows a fresh busy entry
    p_start_after_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wcyc_start_o |-> (busy && !$past(busy)));
endmodule

// File: rtl/spi_ee_array.sv
// Register-based byte storage with one combinational read port and a
// page-wide masked write port.
// Assumes PAGE is a power of two dividing the depth.
module spi_ee_array #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int PAGE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-PW-1:0]    page_base,
    input  logic [PAGE*DW-1:0]  wr_data,
    input  logic [PAGE-1:0]     wr_mask,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);
    localparam int PW = $clog2(PAGE);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // clear on reset, otherwise write the marked bytes of one page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < PAGE; i++) begin
                if (wr_mask[i]) mem[{page_base, PW'(i)}] <= wr_data[i*DW +: DW];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_eeprom_slave.sv
// Top of the serial EEPROM slave: synchronises the bus pins, runs the frame
// engine, guards writes and holds the byte storage.
// Assumes SCK at least 4x slower than clk; select and pause move with SCK low.
module spi_eeprom_slave #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_BYTES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic si_i,
    input  logic hold_n_i,
    input  logic wp_n_i,
    input  logic wcyc_done_i,
    output logic so_o,
    output logic so_oe_o,
    output logic wcyc_start_o
);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [4:0]                  pins;
    logic                        busy, wel_set, wel_clr, arr_commit, sr_commit, arr_grant;
    logic [DATA_W-1:0]           status, rd_data;
    logic [ADDR_W-1:0]           rd_addr;
    logic [ADDR_W-PW-1:0]        page_base;
    logic [1:0]                  region, sr_level;
    logic [PAGE_BYTES*DATA_W-1:0] stage_data;
    logic [PAGE_BYTES-1:0]       stage_mask;

    // pin order: 0 sck, 1 select, 2 data in, 3 pause, 4 protect
    spi_ee_sync #(.N(5), .STAGES(2), .RST_VAL(5'b11000)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({wp_n_i, hold_n_i, si_i, cs_n_i, sck_i}),
        .level_o (pins)
    );

    spi_ee_protocol #(.AW(ADDR_W), .DW(DATA_W), .PAGE(PAGE_BYTES)) u_proto (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_lvl    (pins[0]),
        .cs_n_lvl   (pins[1]),
        .si_lvl     (pins[2]),
        .hold_n_lvl (pins[3]),
        .busy       (busy),
        .status     (status),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wel_set    (wel_set),
        .wel_clr    (wel_clr),
        .arr_commit (arr_commit),
        .sr_commit  (sr_commit),
        .page_base  (page_base),
        .region     (region),
        .stage_data (stage_data),
        .stage_mask (stage_mask),
        .sr_level   (sr_level),
        .so_o       (so_o),
        .so_oe_o    (so_oe_o)
    );

    spi_ee_guard #(.DW(DATA_W)) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .wp_n_lvl     (pins[4]),
        .wel_set      (wel_set),
        .wel_clr      (wel_clr),
        .arr_commit   (arr_commit),
        .sr_commit    (sr_commit),
        .region       (region),
        .sr_level     (sr_level),
        .wcyc_done_i  (wcyc_done_i),
        .busy         (busy),
        .arr_grant    (arr_grant),
        .status       (status),
        .wcyc_start_o (wcyc_start_o)
    );

    spi_ee_array #(.AW(ADDR_W), .DW(DATA_W), .PAGE(PAGE_BYTES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (arr_grant),
        .page_base (page_base),
        .wr_data   (stage_data),
        .wr_mask   (stage_mask),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );
endmodule

// File: tb/spi_eeprom_slave_tb.sv
// Directed bench for the serial EEPROM slave: one task per scenario.
module spi_eeprom_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1, done = 1'b0;
    logic so, so_oe, wstart;

    int checks = 0, errors = 0, starts = 0;
    logic mode3 = 1'b0;
    logic oe_seen;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    spi_eeprom_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .hold_n_i(hold_n), .wp_n_i(wp_n), .wcyc_done_i(done),
        .so_o(so), .so_oe_o(so_oe), .wcyc_start_o(wstart)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (wstart) starts++;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic r);
        sck = 1'b0;
        si  = b;
        wait_h();
        r = so;
        if (so_oe) oe_seen = 1'b1;
        sck = 1'b1;
        wait_h();
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            bit_x(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic sel_on();
        sck = mode3;
        wait_h();
        cs_n = 1'b0;
        oe_seen = 1'b0;
        wait_h();
    endtask

    task automatic sel_off();
        if (!mode3) sck = 1'b0;
        wait_h();
        cs_n = 1'b1;
        wait_h();
        wait_h();
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel_on(); xbyte(op, d); sel_off();
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] d;
        sel_on(); xbyte(8'h05, d); xbyte(8'h00, v); sel_off();
    endtask

    // write n bytes from wbuf at address a, then tail extra bits
    task automatic wr_arr(input logic [7:0] a, input int n, input int tail);
        logic [7:0] d;
        sel_on();
        xbyte(8'h02, d);
        xbyte(a, d);
        for (int i = 0; i < n; i++) xbyte(wbuf[i], d);
        for (int i = 0; i < tail; i++) begin
            logic r;
            bit_x(1'b1, r);
        end
        sel_off();
    endtask

    task automatic rd_arr(input logic [7:0] a, input int n);
        logic [7:0] d;
        sel_on();
        xbyte(8'h03, d);
        xbyte(a, d);
        for (int i = 0; i < n; i++) xbyte(8'h00, rbuf[i]);
        sel_off();
    endtask

    task automatic wsr(input logic [7:0] v);
        logic [7:0] d;
        sel_on(); xbyte(8'h01, d); xbyte(v, d); sel_off();
    endtask

    task automatic cycle_done();
        repeat (4) @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R8", "oe after reset", so_oe, 1'b0);
        chk("R10", "start after reset", wstart, 1'b0);
        // select held low since reset: no falling edge seen, commands ignored
        oe_seen = 1'b0;
        xbyte(8'h05, d); xbyte(8'h00, d);
        chk("R8", "no frame without select fall", oe_seen, 1'b0);
        sck = 1'b0; wait_h(); cs_n = 1'b1; wait_h(); wait_h();
    endtask

    task automatic t_latch();
        logic [7:0] v;
        rdsr(v); chk("R6", "initial status", v, 8'h00);
        cmd1(8'h06); rdsr(v); chk("R5", "latch set", v, 8'h02);
        cmd1(8'h04); rdsr(v); chk("R5", "latch cleared", v, 8'h00);
        wbuf[0] = 8'h5A;
        wr_arr(8'h08, 1, 0);
        chk("R5", "no start without latch", starts, 0);
    endtask

    task automatic t_page_write();
        logic [7:0] v;
        int s0 = starts;
        cmd1(8'h06);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr_arr(8'h10, 4, 0);
        chk("R10", "start pulse on commit", starts, s0 + 1);
        rdsr(v); chk("R6", "status while busy", v, 8'hFF);
        rd_arr(8'h10, 1);
        chk("R10", "read ignored while busy", oe_seen, 1'b0);
        cmd1(8'h06);
        cycle_done();
        rdsr(v); chk("R10", "latch command ignored while busy", v, 8'h00);
        rd_arr(8'h10, 4);
        chk("R3", "page byte 0", rbuf[0], 8'h11);
        chk("R3", "page byte 3", rbuf[3], 8'h44);
        chk("R2", "sequential read", {rbuf[1], rbuf[2]}, 16'h2233);
    endtask

    task automatic t_page_wrap();
        cmd1(8'h06);
        for (int i = 0; i < 5; i++) wbuf[i] = 8'hA0 + 8'(i);
        wr_arr(8'h22, 5, 0);
        cycle_done();
        rd_arr(8'h20, 4);
        chk("R3", "page wrap contents", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'hA2A3A4A1);
    endtask

    task automatic t_read_wrap();
        cmd1(8'h06);
        wbuf[0] = 8'hF0; wbuf[1] = 8'hF1; wbuf[2] = 8'hF2; wbuf[3] = 8'hF3;
        wr_arr(8'hFC, 4, 0);
        cycle_done();
        cmd1(8'h06);
        wbuf[0] = 8'hB0;
        wr_arr(8'h00, 1, 0);
        cycle_done();
        rd_arr(8'hFE, 3);
        chk("R2", "read wraps past top", {rbuf[0], rbuf[1], rbuf[2]}, 24'hF2F3B0);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        int s0 = starts;
        cmd1(8'h06);
        wbuf[0] = 8'hC5;
        wr_arr(8'h30, 1, 3);
        chk("R4", "no start on partial byte", starts, s0);
        wr_arr(8'h30, 0, 0);
        chk("R4", "no start without data", starts, s0);
        rdsr(v); chk("R4", "latch kept after discard", v, 8'h02);
        rd_arr(8'h30, 1);
        chk("R4", "storage untouched", rbuf[0], 8'h00);
        cmd1(8'h04);
    endtask

    task automatic t_wp();
        logic [7:0] v;
        int s0 = starts;
        wp_n = 1'b0;
        cmd1(8'h06);
        wbuf[0] = 8'h77;
        wr_arr(8'h40, 1, 0);
        wp_n = 1'b1;
        chk("R5", "protect pin blocks commit", starts, s0);
        rdsr(v); chk("R5", "latch survives blocked write", v, 8'h02);
        cmd1(8'h04);
        rd_arr(8'h40, 1);
        chk("R5", "protected write left storage", rbuf[0], 8'h00);
    endtask

    task automatic t_levels();
        logic [7:0] v;
        int s0;
        cmd1(8'h06); wsr(8'h04); cycle_done();
        rdsr(v); chk("R7", "level 1 in status", v, 8'h04);
        s0 = starts;
        cmd1(8'h06);
        wbuf[0] = 8'h99;
        wr_arr(8'hC4, 1, 0);
        chk("R7", "level 1 guards top quarter", starts, s0);
        wr_arr(8'h84, 1, 0);
        chk("R7", "level 1 leaves 0x84 open", starts, s0 + 1);
        cycle_done();
        rd_arr(8'h84, 1);
        chk("R7", "open write stored", rbuf[0], 8'h99);
        cmd1(8'h06); wsr(8'h08); cycle_done();
        s0 = starts;
        cmd1(8'h06);
        wr_arr(8'h84, 1, 0);
        chk("R7", "level 2 guards upper half", starts, s0);
        wsr(8'h00); cycle_done();
        rdsr(v); chk("R7", "level cleared", v, 8'h00);
    endtask

    task automatic t_unknown();
        logic [7:0] d;
        sel_on(); xbyte(8'hA5, d); xbyte(8'h00, d); sel_off();
        chk("R8", "unknown command keeps output off", oe_seen, 1'b0);
    endtask

    task automatic t_mode3();
        mode3 = 1'b1;
        rd_arr(8'h10, 2);
        chk("R1", "mode 3 read", {rbuf[0], rbuf[1]}, 16'h1122);
        mode3 = 1'b0;
        sck = 1'b0;
        wait_h();
    endtask

    task automatic t_hold();
        logic [7:0] d, b0, b1;
        logic r;
        sel_on();
        xbyte(8'h03, d);
        xbyte(8'h20, d);
        for (int i = 7; i >= 4; i--) begin
            bit_x(1'b0, r);
            b0[i] = r;
        end
        sck = 1'b0; wait_h();
        hold_n = 1'b0; wait_h();
        chk("R9", "output off while paused", so_oe, 1'b0);
        si = 1'b1; sck = 1'b1; wait_h();
        sck = 1'b0; wait_h();
        sck = 1'b1; wait_h();
        sck = 1'b0; wait_h();
        hold_n = 1'b1; wait_h();
        for (int i = 3; i >= 0; i--) begin
            bit_x(1'b0, r);
            b0[i] = r;
        end
        xbyte(8'h00, b1);
        sel_off();
        chk("R9", "byte across pause", b0, 8'hA2);
        chk("R9", "next byte after pause", b1, 8'hA3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_latch();
        t_page_write();
        t_page_wrap();
        t_read_wrap();
        t_abort();
        t_wp();
        t_levels();
        t_unknown();
        t_mode3();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule